// File: doc/BRIEF.md
# Word-Packing UART Receive Path

This block is the receive half of a serial port. It recovers 8-bit characters with no parity and one stop bit from an asynchronous line. The line is sampled on an oversampling tick that the surrounding logic supplies. The characters are gathered four at a time into 32-bit words, and each complete word is written into a receive FIFO. A bus host drains that FIFO one word per read. A level interrupt tells the host that enough words are waiting. A stale interrupt tells it that the line has gone quiet while a partial word, or any characters not yet reported, remain. At that point the partial word is pushed into the FIFO, and a snapshot of the character count since the transfer was armed lets software know how many bytes of the last word are real.

Two state machines drive the block. The character receiver moves through RX_IDLE, RX_START, RX_DATA, RX_STOP and RX_HOLD:
- RX_IDLE to RX_START on a tick that sees the line low.
- RX_START back to RX_IDLE if the half-bit check finds the line high (a glitch). Otherwise RX_START to RX_DATA.
- RX_DATA to RX_STOP after the eighth data bit.
- RX_STOP to RX_IDLE when the stop bit is high. When the stop bit is low, RX_STOP goes to RX_HOLD, and RX_HOLD returns to RX_IDLE once the line is high again.

The stale machine has two states. STL_DISARMED goes to STL_WATCH on the stale-enable command. STL_WATCH goes back to STL_DISARMED on any stale event, whether a timeout or a forced one. Stale detection is therefore one-shot until software enables it again.

Software arms a transfer by writing the transfer-length register, enables stale detection with a command, and then services the level and stale interrupts. Error and break events are cleared with their own commands.

Top module: `uart_wpack_rx`

## Requirements
- R1: Received characters are packed into 32-bit FIFO words. The first character of each group of four goes in bits [7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24]. A word enters the FIFO when its fourth character arrives.
- R2: The status register (address 5) reports the FIFO word count in bits [7:0] and the number of characters waiting in the packing word (0 to 3) in bits [10:8].
- R3: `irq_level` is high whenever the FIFO word count is greater than or equal to the watermark register (address 1). The watermark resets to three quarters of the FIFO depth.
- R4: A timeout stale event fires when all of the following hold: the stale machine is in STL_WATCH, at least one character has arrived since the last stale event, the stale field (address 2, 5 bits) is nonzero, and the line has been idle for at least that many character-times of 10 bit-times each. The event pushes any partial word into the FIFO with its unused upper bytes zero, latches the snapshot, sets `irq_stale` (status bit 17) and returns the machine to STL_DISARMED.
- R5: No timeout stale event fires while the stale field is zero, or before command 2 (stale enable) has been issued again after the previous stale event.
- R6: Writing the transfer-length register (address 3) arms a transfer and clears the running character count. The snapshot register (address 4) reads the number of characters received since the last arm, captured at the most recent stale event.
- R7: Command 3 (force stale) performs a stale event at once, whatever the stale state or timeout. It flushes the packing word, latches the snapshot and sets `irq_stale`.
- R8: Command 1 clears `irq_stale`.
- R9: A word pushed while the FIFO is full is dropped and sets the overrun flag (status bit 16). The words already in the FIFO are unchanged. Command 4 clears the flag.
- R10: A frame whose data bits and stop bit are all zero is a break start. It sets `irq_break` (status bit 18) and delivers one zero character into the packing word. Command 5 clears `irq_break`.
- R11: A read of the data address (0) while the FIFO is empty returns zero and leaves every count and flag unchanged.
- R12: After reset, the FIFO and packing word are empty, every interrupt and flag is low, the snapshot and stale field are zero, and the watermark holds its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial receive line, idle high |
| baud_tick | input | 1 | One-cycle pulse at OVS times the bit rate |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the FIFO at address 0 |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of the read |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command: 1 clear stale, 2 enable stale, 3 force stale, 4 clear error, 5 clear break |
| irq_level | output | 1 | FIFO at or above the watermark |
| irq_stale | output | 1 | Stale event pending |
| irq_break | output | 1 | Break start seen |

## Verification
A character becomes visible in the packing count one clock edge after its stop bit is sampled. A completed word becomes visible in the FIFO count at the same edge. The bench therefore reads status several cycles after the last serial bit of each frame has been driven. Register writes and commands take effect at the next edge, and the bench samples one or more cycles after the strobe. The stale timeout can only be bounded to within a tick of the oversampling clock, so the bench checks it with two samples, one well inside the idle window and one well past it, rather than at a single cycle.

// File: rtl/wpack_pkg.sv
package wpack_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_t;

    typedef enum logic {
        STL_DISARMED,
        STL_WATCH
    } stale_state_t;

    typedef enum logic [2:0] {
        CMD_NOP         = 3'd0,
        CMD_CLR_STALE   = 3'd1,
        CMD_EN_STALE    = 3'd2,
        CMD_FORCE_STALE = 3'd3,
        CMD_CLR_ERR     = 3'd4,
        CMD_CLR_BREAK   = 3'd5
    } cmd_t;

    localparam logic [2:0] ADR_DATA  = 3'd0;
    localparam logic [2:0] ADR_WMARK = 3'd1;
    localparam logic [2:0] ADR_STALE = 3'd2;
    localparam logic [2:0] ADR_XLEN  = 3'd3;
    localparam logic [2:0] ADR_SNAP  = 3'd4;
    localparam logic [2:0] ADR_STAT  = 3'd5;

endpackage

// File: rtl/wpack_deser.sv
module wpack_deser
    import wpack_pkg::*;
#(
    parameter int OVS = 4,
    parameter int CW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd,
    input  logic          tick,
    output logic          chr_valid,
    output logic [CW-1:0] chr_data,
    output logic          brk_start,
    output logic          line_idle
);
    localparam int OW = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int BW = $clog2(CW);

    logic          rx_m, rx_s;
    rx_state_t     st_q, st_d;
    logic [OW-1:0] cnt_q, cnt_d;
    logic [BW-1:0] bit_q, bit_d;
    logic [CW-1:0] shf_q, shf_d;

    // two-flop synchronizer on the asynchronous line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= rxd;
            rx_s <= rx_m;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RX_IDLE;
            cnt_q <= '0;
            bit_q <= '0;
            shf_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            bit_q <= bit_d;
            shf_q <= shf_d;
        end
    end

    // next state and output pulses
    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_q;
        bit_d     = bit_q;
        shf_d     = shf_q;
        chr_valid = 1'b0;
        brk_start = 1'b0;
        unique case (st_q)
            RX_IDLE: begin
                if (tick && !rx_s) begin
                    st_d  = RX_START;
                    cnt_d = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (cnt_q == OW'(OVS/2 - 1)) begin
                        cnt_d = '0;
                        bit_d = '0;
                        st_d  = rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (cnt_q == OW'(OVS - 1)) begin
                        cnt_d = '0;
                        shf_d = {rx_s, shf_q[CW-1:1]};
                        if (bit_q == BW'(CW - 1)) begin
                            st_d = RX_STOP;
                        end else begin
                            bit_d = bit_q + 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (cnt_q == OW'(OVS - 1)) begin
                        cnt_d     = '0;
                        chr_valid = 1'b1;
                        if (rx_s) begin
                            st_d = RX_IDLE;
                        end else begin
                            st_d      = RX_HOLD;
                            brk_start = (shf_q == '0);
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            RX_HOLD: begin
                if (rx_s) begin
                    st_d = RX_IDLE;
                end
            end
            default: st_d = RX_IDLE;
        endcase
    end

    assign chr_data  = shf_q;
    assign line_idle = (st_q == RX_IDLE) && rx_s;

    AST_STOP_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_STOP) |-> ($past(st_q) == RX_STOP || $past(st_q) == RX_DATA)); // R1

    AST_HOLD_AFTER_LOW_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        brk_start |=> (st_q == RX_HOLD || st_q == RX_IDLE)); // R10

endmodule

// File: rtl/wpack_stale.sv
module wpack_stale
    import wpack_pkg::*;
#(
    parameter int OVS = 4,
    parameter int FW  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line_idle,
    input  logic          chr_valid,
    input  logic [FW-1:0] idle_lim,
    input  logic          arm_cmd,
    input  logic          force_cmd,
    output logic          stale_evt
);
    localparam int CHT = 10 * OVS;
    localparam int TW  = $clog2(CHT);

    stale_state_t  st_q, st_d;
    logic [TW-1:0] tcnt_q;
    logic [FW-1:0] icnt_q;
    logic          act_q;
    logic          timeout;

    // idle timer in character-times, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            icnt_q <= '0;
        end else if (!line_idle || chr_valid) begin
            tcnt_q <= '0;
            icnt_q <= '0;
        end else if (tick) begin
            if (tcnt_q == TW'(CHT - 1)) begin
                tcnt_q <= '0;
                if (icnt_q != '1) begin
                    icnt_q <= icnt_q + 1'b1;
                end
            end else begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end
    end

    // characters seen since the previous stale event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else if (stale_evt) begin
            act_q <= 1'b0;
        end else if (chr_valid) begin
            act_q <= 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= STL_DISARMED;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            STL_DISARMED: if (arm_cmd)   st_d = STL_WATCH;
            STL_WATCH:    if (stale_evt) st_d = STL_DISARMED;
            default:      st_d = STL_DISARMED;
        endcase
    end

    // outputs
    always_comb begin
        timeout   = (st_q == STL_WATCH) && act_q && (idle_lim != '0) && (icnt_q >= idle_lim);
        stale_evt = timeout || force_cmd;
    end

    AST_STALE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> (st_q == STL_DISARMED)); // R4

    AST_STALE_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout); // R5

endmodule

// File: rtl/wpack_packer.sv
module wpack_packer #(
    parameter int CW    = 8,
    parameter int LANES = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           chr_valid,
    input  logic [CW-1:0]                  chr_data,
    input  logic                           flush,
    output logic                           push,
    output logic [CW*LANES-1:0]            word_out,
    output logic [$clog2(LANES+1)-1:0]     pend_cnt
);
    localparam int WW = CW * LANES;
    localparam int LW = $clog2(LANES + 1);

    logic [WW-1:0] word_q, m_word;
    logic [LW-1:0] cnt_q, m_cnt;

    always_comb begin
        m_word = word_q;
        m_cnt  = cnt_q;
        if (chr_valid) begin
            m_word[int'(cnt_q)*CW +: CW] = chr_data;
            m_cnt = cnt_q + 1'b1;
        end
        push     = (m_cnt == LW'(LANES)) || (flush && (m_cnt != '0));
        word_out = m_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
        end else if (push) begin
            word_q <= '0;
            cnt_q  <= '0;
        end else begin
            word_q <= m_word;
            cnt_q  <= m_cnt;
        end
    end

    assign pend_cnt = cnt_q;

    AST_PACK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && !flush && cnt_q != LW'(LANES - 1)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

    AST_PACK_BELOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < LW'(LANES)); // R1

endmodule

// File: rtl/wpack_fifo.sv
module wpack_fifo #(
    parameter int WW    = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WW-1:0]                wdata,
    input  logic                         pop,
    output logic [WW-1:0]                rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         drop
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [WW-1:0]   mem [DEPTH];
    logic [AW-1:0]   wp_q, rp_q;
    logic [CNTW-1:0] cnt_q;
    logic            do_push, do_pop;

    assign do_pop  = pop && (cnt_q != '0);
    assign do_push = push && ((cnt_q != CNTW'(DEPTH)) || do_pop);
    assign drop    = push && !do_push;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp_q] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            end
            if (do_pop) begin
                rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            end
            cnt_q <= cnt_q + CNTW'(do_push) - CNTW'(do_pop);
        end
    end

    assign rdata = (cnt_q != '0) ? mem[rp_q] : '0;
    assign count = cnt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNTW'(DEPTH)); // R9

    AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (cnt_q == $past(cnt_q))); // R9

    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && cnt_q == '0 && !push) |=> (cnt_q == '0)); // R11

endmodule

// File: rtl/uart_wpack_rx.sv
module uart_wpack_rx
    import wpack_pkg::*;
#(
    parameter int OVS   = 4,
    parameter int DEPTH = 8,
    parameter int CNT_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rxd,
    input  logic        baud_tick,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_code,
    output logic        irq_level,
    output logic        irq_stale,
    output logic        irq_break
);
    localparam int CW    = 8;
    localparam int LANES = 4;
    localparam int WW    = CW * LANES;
    localparam int FW    = 5;
    localparam int CNTW  = $clog2(DEPTH + 1);
    localparam int LW    = $clog2(LANES + 1);

    logic            chr_valid, brk_start, line_idle;
    logic [CW-1:0]   chr_data;
    logic            stale_evt, push, drop, pop;
    logic [WW-1:0]   pack_word, fifo_rdata;
    logic [LW-1:0]   pend;
    logic [CNTW-1:0] fifo_cnt;

    logic [CNTW-1:0]  wmark_q;
    logic [FW-1:0]    stale_lim_q;
    logic [31:0]      xlen_q;
    logic [CNT_W-1:0] total_q, total_next, snap_q;
    logic             ovr_q, stl_q, brk_q;
    logic             arm_wr;
    logic             c_clr_stale, c_en_stale, c_force, c_clr_err, c_clr_brk;
    logic [31:0]      stat;

    assign c_clr_stale = cmd_valid && (cmd_code == CMD_CLR_STALE);
    assign c_en_stale  = cmd_valid && (cmd_code == CMD_EN_STALE);
    assign c_force     = cmd_valid && (cmd_code == CMD_FORCE_STALE);
    assign c_clr_err   = cmd_valid && (cmd_code == CMD_CLR_ERR);
    assign c_clr_brk   = cmd_valid && (cmd_code == CMD_CLR_BREAK);
    assign arm_wr      = reg_wr && (reg_addr == ADR_XLEN);
    assign pop         = reg_rd && (reg_addr == ADR_DATA);

    wpack_deser #(.OVS(OVS), .CW(CW)) i_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .tick      (baud_tick),
        .chr_valid (chr_valid),
        .chr_data  (chr_data),
        .brk_start (brk_start),
        .line_idle (line_idle)
    );

    wpack_stale #(.OVS(OVS), .FW(FW)) i_stale (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .line_idle (line_idle),
        .chr_valid (chr_valid),
        .idle_lim  (stale_lim_q),
        .arm_cmd   (c_en_stale),
        .force_cmd (c_force),
        .stale_evt (stale_evt)
    );

    wpack_packer #(.CW(CW), .LANES(LANES)) i_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .chr_valid (chr_valid),
        .chr_data  (chr_data),
        .flush     (stale_evt),
        .push      (push),
        .word_out  (pack_word),
        .pend_cnt  (pend)
    );

    wpack_fifo #(.WW(WW), .DEPTH(DEPTH)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (pack_word),
        .pop   (pop),
        .rdata (fifo_rdata),
        .count (fifo_cnt),
        .drop  (drop)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wmark_q     <= CNTW'(DEPTH * 3 / 4);
            stale_lim_q <= '0;
            xlen_q      <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADR_WMARK: wmark_q     <= reg_wdata[CNTW-1:0];
                ADR_STALE: stale_lim_q <= reg_wdata[FW-1:0];
                ADR_XLEN:  xlen_q      <= reg_wdata;
                default:   ;
            endcase
        end
    end

    // running count and snapshot
    assign total_next = (arm_wr ? '0 : total_q) + {{(CNT_W-1){1'b0}}, chr_valid};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q <= '0;
            snap_q  <= '0;
        end else begin
            total_q <= total_next;
            if (stale_evt) begin
                snap_q <= total_next;
            end
        end
    end

    // event flags, set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            stl_q <= 1'b0;
            brk_q <= 1'b0;
        end else begin
            if (drop)             ovr_q <= 1'b1;
            else if (c_clr_err)   ovr_q <= 1'b0;
            if (stale_evt)        stl_q <= 1'b1;
            else if (c_clr_stale) stl_q <= 1'b0;
            if (brk_start)        brk_q <= 1'b1;
            else if (c_clr_brk)   brk_q <= 1'b0;
        end
    end

    always_comb begin
        stat             = '0;
        stat[CNTW-1:0]   = fifo_cnt;
        stat[8 +: LW]    = pend;
        stat[16]         = ovr_q;
        stat[17]         = stl_q;
        stat[18]         = brk_q;
    end

    always_comb begin
        case (reg_addr)
            ADR_DATA:  reg_rdata = fifo_rdata;
            ADR_WMARK: reg_rdata = {{(32-CNTW){1'b0}}, wmark_q};
            ADR_STALE: reg_rdata = {{(32-FW){1'b0}}, stale_lim_q};
            ADR_XLEN:  reg_rdata = xlen_q;
            ADR_SNAP:  reg_rdata = {{(32-CNT_W){1'b0}}, snap_q};
            ADR_STAT:  reg_rdata = stat;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq_level = (fifo_cnt >= wmark_q);
    assign irq_stale = stl_q;
    assign irq_break = brk_q;

    AST_STALE_EMPTIES_PACKER: assert property (@(posedge clk) disable iff (!rst_n)
        stale_evt |=> (pend == '0)); // R7

    AST_ARM_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_wr && !chr_valid) |=> (total_q == '0)); // R6

    AST_STALE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        stale_evt |=> irq_stale); // R8

endmodule

// File: tb/test_uart_wpack_rx.sv
module test_uart_wpack_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic        baud_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = 3'd0;
    logic        irq_level, irq_stale, irq_break;

    int errors = 0;
    int checks = 0;
    int tdiv = 0;

    uart_wpack_rx #(.OVS(4), .DEPTH(8), .CNT_W(24)) i_uart_wpack_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .baud_tick (baud_tick),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .irq_level (irq_level),
        .irq_stale (irq_stale),
        .irq_break (irq_break)
    );

    always #2 clk = ~clk;

    // oversampling tick every 4 cycles, 4 ticks per bit
    always @(negedge clk) begin
        tdiv      <= (tdiv == 3) ? 0 : tdiv + 1;
        baud_tick <= (tdiv == 3);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] c);
        @(negedge clk);
        cmd_code = c; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop);
        @(negedge clk);
        rxd = 1'b0;
        wait_cyc(16);
        for (int k = 0; k < 8; k++) begin
            rxd = b[k];
            wait_cyc(16);
        end
        rxd = stop;
        wait_cyc(16);
        rxd = 1'b1;
        wait_cyc(4);
    endtask

    function automatic logic [31:0] st(input int f, input int p, input int o, input int s, input int b);
        return 32'(f) | (32'(p) << 8) | (32'(o) << 16) | (32'(s) << 17) | (32'(b) << 18);
    endfunction

    function automatic logic [7:0] cva(input int i);
        return 8'(i * 37 + 5);
    endfunction

    function automatic logic [7:0] cvb(input int i);
        return 8'(i * 11 + 200);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d, s0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);

        // R12 reset state
        chk("R12 irq_level", 32'(irq_level), 32'd0);
        chk("R12 irq_stale", 32'(irq_stale), 32'd0);
        chk("R12 irq_break", 32'(irq_break), 32'd0);
        rd_reg(3'd5, d); chk("R12 status", d, 32'd0);
        rd_reg(3'd4, d); chk("R12 snapshot", d, 32'd0);
        rd_reg(3'd1, d); chk("R12 watermark", d, 32'd6);
        rd_reg(3'd2, d); chk("R12 stale field", d, 32'd0);

        // R11 empty read
        rd_reg(3'd0, d); chk("R11 empty data", d, 32'd0);
        rd_reg(3'd5, d); chk("R11 status after empty read", d, 32'd0);

        // R1 R2 R3 sweep of 24 characters
        for (int i = 0; i < 24; i++) begin
            send_byte(cva(i), 1'b1);
            rd_reg(3'd5, d);
            chk("R2 status word and pack count", d, st((i + 1) / 4, (i + 1) % 4, 0, 0, 0));
            chk("R3 level vs watermark 6", 32'(irq_level), 32'(((i + 1) / 4) >= 6));
        end
        for (int j = 0; j < 6; j++) begin
            rd_reg(3'd0, d);
            chk("R1 packed word order", d, {cva(4*j+3), cva(4*j+2), cva(4*j+1), cva(4*j)});
            chk("R3 level after pop", 32'(irq_level), 32'd0);
        end
        rd_reg(3'd5, d); chk("R2 drained", d, 32'd0);

        // R9 overrun with watermark 8
        wr_reg(3'd1, 32'd8);
        for (int i = 0; i < 32; i++) send_byte(cvb(i), 1'b1);
        rd_reg(3'd5, d); chk("R9 full without overrun", d, st(8, 0, 0, 0, 0));
        chk("R3 level at watermark 8", 32'(irq_level), 32'd1);
        for (int i = 32; i < 36; i++) send_byte(cvb(i), 1'b1);
        rd_reg(3'd5, d); chk("R9 overrun set", d, st(8, 0, 1, 0, 0));
        rd_reg(3'd0, d); chk("R9 first word intact", d, {cvb(3), cvb(2), cvb(1), cvb(0)});
        cmd(3'd4);
        wait_cyc(1);
        rd_reg(3'd5, d); chk("R9 overrun cleared", d, st(7, 0, 0, 0, 0));
        for (int j = 1; j < 8; j++) begin
            rd_reg(3'd0, d);
            chk("R9 kept words", d, {cvb(4*j+3), cvb(4*j+2), cvb(4*j+1), cvb(4*j)});
        end

        // R4 R6 timeout stale
        wr_reg(3'd1, 32'd6);
        wr_reg(3'd2, 32'd2);
        wr_reg(3'd3, 32'h00FF_FFFF);
        cmd(3'd2);
        for (int i = 0; i < 5; i++) send_byte(cva(i + 50), 1'b1);
        chk("R4 no stale while active", 32'(irq_stale), 32'd0);
        wait_cyc(200);
        chk("R4 no stale before limit", 32'(irq_stale), 32'd0);
        wait_cyc(200);
        chk("R4 stale after limit", 32'(irq_stale), 32'd1);
        rd_reg(3'd4, d); chk("R6 snapshot five", d, 32'd5);
        rd_reg(3'd5, d); chk("R4 partial flushed", d, st(2, 0, 0, 1, 0));
        rd_reg(3'd0, d); chk("R4 full word", d, {cva(53), cva(52), cva(51), cva(50)});
        rd_reg(3'd0, d); chk("R4 partial word", d, {24'd0, cva(54)});
        cmd(3'd1);
        wait_cyc(1);
        chk("R8 stale cleared", 32'(irq_stale), 32'd0);

        // R5 no re-enable, then zero field
        send_byte(8'h3C, 1'b1);
        wait_cyc(800);
        chk("R5 disarmed no stale", 32'(irq_stale), 32'd0);
        rd_reg(3'd5, d); chk("R5 char still packed", d, st(0, 1, 0, 0, 0));
        wr_reg(3'd2, 32'd0);
        cmd(3'd2);
        wait_cyc(800);
        chk("R5 zero field no stale", 32'(irq_stale), 32'd0);
        wr_reg(3'd2, 32'd1);
        wait_cyc(3);
        chk("R4 stale once field nonzero", 32'(irq_stale), 32'd1);
        rd_reg(3'd4, d); chk("R6 snapshot six", d, 32'd6);
        rd_reg(3'd0, d); chk("R4 single char word", d, 32'h0000_003C);
        cmd(3'd1);

        // R7 force stale
        wr_reg(3'd3, 32'h00FF_FFFF);
        send_byte(8'hA1, 1'b1);
        send_byte(8'hB2, 1'b1);
        send_byte(8'hC3, 1'b1);
        rd_reg(3'd5, d); chk("R7 three pending", d, st(0, 3, 0, 0, 0));
        cmd(3'd3);
        wait_cyc(2);
        chk("R7 forced stale irq", 32'(irq_stale), 32'd1);
        rd_reg(3'd5, d); chk("R7 flushed status", d, st(1, 0, 0, 1, 0));
        rd_reg(3'd4, d); chk("R7 snapshot three", d, 32'd3);
        rd_reg(3'd0, d); chk("R7 forced word", d, 32'h00C3_B2A1);
        cmd(3'd1);

        // R10 break
        @(negedge clk);
        rxd = 1'b0;
        wait_cyc(192);
        rxd = 1'b1;
        wait_cyc(40);
        chk("R10 break irq", 32'(irq_break), 32'd1);
        rd_reg(3'd5, d); chk("R10 zero char packed", d, st(0, 1, 0, 0, 1));
        send_byte(8'hA5, 1'b1);
        cmd(3'd3);
        wait_cyc(2);
        rd_reg(3'd0, d); chk("R10 break char in word", d, 32'h0000_A500);
        cmd(3'd5);
        cmd(3'd1);
        wait_cyc(1);
        chk("R10 break cleared", 32'(irq_break), 32'd0);

        // R11 empty read leaves state
        rd_reg(3'd5, s0);
        rd_reg(3'd0, d); chk("R11 empty data again", d, 32'd0);
        rd_reg(3'd5, d); chk("R11 status unchanged", d, s0);
        chk("R11 status idle", s0, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule